// File: doc/BRIEF.md
# Handshaked Access-Count Register

This block is a 64-bit memory-mapped counter that software moves by touching it rather than by loading a value into it. Every completed write adds one and every completed read subtracts one. A read also hands back the count as it stood before the subtraction. The write channel carries no data at all. The only thing that matters is that a write happened.

The read channel and the write channel each have a request handshake and a response handshake. Each channel keeps a one-bit busy state. An idle channel takes the next valid request and becomes busy, and it stays busy until its response is taken. The counter changes only on the clock edge that completes a response. A request whose address does not match its channel's offset still gets a response, but it leaves the counter alone. Reads sit at offset 0x00 and writes at offset 0x08.

Top module: `access_count_reg`

## Requirements
- R1: After a synchronous active-high reset the count is zero, both request-ready outputs are high and both response-valid outputs are low.
- R2: A channel's request ready is high exactly when that channel is idle. A valid request seen while idle makes the response valid, and drops request ready, from the next cycle.
- R3: A pending response stays valid until its response ready is sampled high. While no response completes, the count does not change.
- R4: A write request at offset 0x08, once its response completes, raises the count by one on the next cycle. The write channel has no data field.
- R5: A read request at offset 0x00 returns, in the cycle its response completes, the count before the decrement. The count falls by one on the next cycle.
- R6: When a read completion and a write completion at matching offsets fall on the same edge, the count is left unchanged.
- R7: The count wraps modulo 2^64 in both directions: zero minus one gives all ones, and all ones plus one gives zero.
- R8: A request at any offset other than its channel's is accepted and answered with the normal handshake. It leaves the count unchanged, and a read of this kind returns zero data.
- R9: If response ready is held high, a channel completes its response in the first busy cycle. It is ready again one cycle later, so a held request is served every second cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req_valid | input | 1 | Read request valid |
| rd_req_addr | input | ADDR_W | Read request offset |
| rd_req_ready | output | 1 | Read channel idle, request can be taken |
| rd_rsp_valid | output | 1 | Read response pending |
| rd_rsp_ready | input | 1 | Read response accepted |
| rd_rsp_data | output | CNT_W | Read response data |
| wr_req_valid | input | 1 | Write request valid |
| wr_req_addr | input | ADDR_W | Write request offset |
| wr_req_ready | output | 1 | Write channel idle, request can be taken |
| wr_rsp_valid | output | 1 | Write response pending |
| wr_rsp_ready | input | 1 | Write response accepted |

## Verification
The bench first reads from zero and then writes past all ones, to cover the two wrap edges. A design that saturated, or that had the wrong width, would return a stuck or truncated value on the reads that follow. It holds response ready low for several cycles to catch a counter that moves when the request is accepted instead of when the response completes. It also fires both channels into the same edge, which exposes any priority between increment and decrement as a one-count drift. Requests at wrong offsets, back-to-back requests with response ready held high, and a long stretch of random traffic check that mismatched requests never touch the count and that a channel never takes a second request while busy.

// File: rtl/acnt_pkg.sv
package acnt_pkg;
  typedef enum logic {
    PORT_IDLE = 1'b0,
    PORT_RESP = 1'b1
  } port_state_e;

  localparam int unsigned NPORT   = 2;
  localparam int unsigned PORT_RD = 0;
  localparam int unsigned PORT_WR = 1;
endpackage

// File: rtl/acnt_port.sv
module acnt_port
  import acnt_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter logic [ADDR_W-1:0] OFFSET = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              hit
);
  port_state_e st_q;
  logic        hit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= PORT_IDLE;
      hit_q <= 1'b0;
    end else begin
      case (st_q)
        PORT_IDLE: if (req_valid) begin
          st_q  <= PORT_RESP;
          hit_q <= (req_addr == OFFSET);
        end
        PORT_RESP: if (rsp_ready) st_q <= PORT_IDLE;
        default:   st_q <= PORT_IDLE;
      endcase
    end
  end

  assign req_ready = (st_q == PORT_IDLE);
  assign rsp_valid = (st_q == PORT_RESP);
  assign hit       = hit_q;
endmodule

// File: rtl/acnt_counter.sv
module acnt_counter #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else begin
      case ({inc, dec})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign count = cnt_q;
endmodule

// File: rtl/acnt_rdata.sv
module acnt_rdata #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             hit,
  input  logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] data
);
  always_comb begin
    data = '0;
    if (hit) data = count;
  end
endmodule

// File: rtl/access_count_reg.sv
module access_count_reg
  import acnt_pkg::*;
#(
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned ADDR_W = 12,
  parameter logic [ADDR_W-1:0] RD_OFS = 'h000,
  parameter logic [ADDR_W-1:0] WR_OFS = 'h008
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req_valid,
  input  logic [ADDR_W-1:0] rd_req_addr,
  output logic              rd_req_ready,
  output logic              rd_rsp_valid,
  input  logic              rd_rsp_ready,
  output logic [CNT_W-1:0]  rd_rsp_data,
  input  logic              wr_req_valid,
  input  logic [ADDR_W-1:0] wr_req_addr,
  output logic              wr_req_ready,
  output logic              wr_rsp_valid,
  input  logic              wr_rsp_ready
);
  logic [NPORT-1:0]  req_valid_a, req_ready_a, rsp_valid_a, rsp_ready_a, hit_a, done_a;
  logic [ADDR_W-1:0] req_addr_a [NPORT];
  logic [CNT_W-1:0]  cnt_q;
  logic              rd_done, wr_done;

  assign req_valid_a[PORT_RD] = rd_req_valid;
  assign req_valid_a[PORT_WR] = wr_req_valid;
  assign req_addr_a[PORT_RD]  = rd_req_addr;
  assign req_addr_a[PORT_WR]  = wr_req_addr;
  assign rsp_ready_a[PORT_RD] = rd_rsp_ready;
  assign rsp_ready_a[PORT_WR] = wr_rsp_ready;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    localparam logic [ADDR_W-1:0] OFS = (p == PORT_RD) ? RD_OFS : WR_OFS;
    acnt_port #(.ADDR_W(ADDR_W), .OFFSET(OFS)) u_port (
      .clk       (clk),
      .rst       (rst),
      .req_valid (req_valid_a[p]),
      .req_addr  (req_addr_a[p]),
      .req_ready (req_ready_a[p]),
      .rsp_valid (rsp_valid_a[p]),
      .rsp_ready (rsp_ready_a[p]),
      .hit       (hit_a[p])
    );
    assign done_a[p] = rsp_valid_a[p] & rsp_ready_a[p] & hit_a[p];
  end

  assign rd_done = done_a[PORT_RD];
  assign wr_done = done_a[PORT_WR];

  acnt_counter #(.CNT_W(CNT_W)) u_counter (
    .clk   (clk),
    .rst   (rst),
    .inc   (wr_done),
    .dec   (rd_done),
    .count (cnt_q)
  );

  acnt_rdata #(.CNT_W(CNT_W)) u_rdata (
    .hit   (hit_a[PORT_RD]),
    .count (cnt_q),
    .data  (rd_rsp_data)
  );

  assign rd_req_ready = req_ready_a[PORT_RD];
  assign wr_req_ready = req_ready_a[PORT_WR];
  assign rd_rsp_valid = rsp_valid_a[PORT_RD];
  assign wr_rsp_valid = rsp_valid_a[PORT_WR];
endmodule

// File: rtl/acnt_checker.sv
module acnt_checker #(
  parameter int unsigned CNT_W = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             rd_req_valid,
  input logic             rd_req_ready,
  input logic             rd_rsp_valid,
  input logic             rd_rsp_ready,
  input logic [CNT_W-1:0] rd_rsp_data,
  input logic             wr_req_valid,
  input logic             wr_req_ready,
  input logic             wr_rsp_valid,
  input logic             wr_rsp_ready,
  input logic [CNT_W-1:0] cnt,
  input logic             rd_done,
  input logic             wr_done
);
  AST_RD_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    rd_req_valid && rd_req_ready |=> rd_rsp_valid && !rd_req_ready); // R2
  AST_WR_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    wr_req_valid && wr_req_ready |=> wr_rsp_valid && !wr_req_ready); // R2
  AST_RD_RSP_HOLD: assert property (@(posedge clk) disable iff (rst)
    rd_rsp_valid && !rd_rsp_ready |=> rd_rsp_valid); // R3
  AST_WR_RSP_HOLD: assert property (@(posedge clk) disable iff (rst)
    wr_rsp_valid && !wr_rsp_ready |=> wr_rsp_valid); // R3
  AST_CNT_QUIET: assert property (@(posedge clk) disable iff (rst)
    !rd_done && !wr_done |=> $stable(cnt)); // R3
  AST_CNT_INC: assert property (@(posedge clk) disable iff (rst)
    wr_done && !rd_done |=> cnt == $past(cnt) + CNT_W'(1)); // R4
  AST_CNT_DEC: assert property (@(posedge clk) disable iff (rst)
    rd_done && !wr_done |=> cnt == $past(cnt) - CNT_W'(1)); // R5
  AST_RD_DATA: assert property (@(posedge clk) disable iff (rst)
    rd_done |-> rd_rsp_data == cnt); // R5
  AST_CNT_BOTH: assert property (@(posedge clk) disable iff (rst)
    rd_done && wr_done |=> $stable(cnt)); // R6
endmodule

bind access_count_reg acnt_checker #(.CNT_W(CNT_W)) u_acnt_checker (
  .clk          (clk),
  .rst          (rst),
  .rd_req_valid (rd_req_valid),
  .rd_req_ready (rd_req_ready),
  .rd_rsp_valid (rd_rsp_valid),
  .rd_rsp_ready (rd_rsp_ready),
  .rd_rsp_data  (rd_rsp_data),
  .wr_req_valid (wr_req_valid),
  .wr_req_ready (wr_req_ready),
  .wr_rsp_valid (wr_rsp_valid),
  .wr_rsp_ready (wr_rsp_ready),
  .cnt          (cnt_q),
  .rd_done      (rd_done),
  .wr_done      (wr_done)
);

// File: tb/access_count_reg_bench.sv
module access_count_reg_bench;
  localparam int CW = 64;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rd_req_valid = 1'b0, wr_req_valid = 1'b0;
  logic [AW-1:0] rd_req_addr = '0, wr_req_addr = '0;
  logic          rd_rsp_ready = 1'b0, wr_rsp_ready = 1'b0;
  logic          rd_req_ready, rd_rsp_valid, wr_req_ready, wr_rsp_valid;
  logic [CW-1:0] rd_rsp_data;

  int    n_chk = 0;
  int    n_bad = 0;
  int    cycles = 0;
  bit    done_flag = 1'b0;
  string tag = "R1";

  // reference model state
  bit          m_rd_busy, m_wr_busy, m_rd_hit, m_wr_hit;
  logic [CW-1:0] m_cnt;

  always #5 clk = ~clk;

  access_count_reg u_access_count_reg (
    .clk(clk), .rst(rst),
    .rd_req_valid(rd_req_valid), .rd_req_addr(rd_req_addr), .rd_req_ready(rd_req_ready),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready), .rd_rsp_data(rd_rsp_data),
    .wr_req_valid(wr_req_valid), .wr_req_addr(wr_req_addr), .wr_req_ready(wr_req_ready),
    .wr_rsp_valid(wr_rsp_valid), .wr_rsp_ready(wr_rsp_ready)
  );

  always @(posedge clk) begin
    if (rst) begin
      m_rd_busy <= 0; m_wr_busy <= 0; m_rd_hit <= 0; m_wr_hit <= 0; m_cnt <= '0;
    end else begin
      bit rd_fin, wr_fin;
      logic [CW-1:0] nxt;
      rd_fin = m_rd_busy && rd_rsp_ready;
      wr_fin = m_wr_busy && wr_rsp_ready;
      nxt = m_cnt;
      if (wr_fin && m_wr_hit) nxt = nxt + 64'd1;
      if (rd_fin && m_rd_hit) nxt = nxt - 64'd1;
      m_cnt <= nxt;
      if (!m_rd_busy && rd_req_valid) begin
        m_rd_busy <= 1; m_rd_hit <= (rd_req_addr == 12'h000);
      end else if (rd_fin) m_rd_busy <= 0;
      if (!m_wr_busy && wr_req_valid) begin
        m_wr_busy <= 1; m_wr_hit <= (wr_req_addr == 12'h008);
      end else if (wr_fin) m_wr_busy <= 0;
    end
  end

  task automatic check(string req, string what, logic [CW-1:0] act, logic [CW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // compare against the model every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done_flag) begin
      string hs;
      hs = (tag == "R9") ? "R9" : "R2";
      check(hs, "rd_req_ready", 64'(rd_req_ready), 64'(!m_rd_busy));
      check(hs, "wr_req_ready", 64'(wr_req_ready), 64'(!m_wr_busy));
      check("R3", "rd_rsp_valid", 64'(rd_rsp_valid), 64'(m_rd_busy));
      check("R3", "wr_rsp_valid", 64'(wr_rsp_valid), 64'(m_wr_busy));
      if (m_rd_busy) check(tag, "rd_rsp_data", rd_rsp_data, m_rd_hit ? m_cnt : '0);
    end
  end

  task automatic do_read(logic [AW-1:0] a, int hold);
    @(negedge clk); rd_req_valid = 1; rd_req_addr = a;
    @(negedge clk); rd_req_valid = 0;
    repeat (hold) @(negedge clk);
    rd_rsp_ready = 1;
    @(negedge clk); rd_rsp_ready = 0;
  endtask

  task automatic do_write(logic [AW-1:0] a, int hold);
    @(negedge clk); wr_req_valid = 1; wr_req_addr = a;
    @(negedge clk); wr_req_valid = 0;
    repeat (hold) @(negedge clk);
    wr_rsp_ready = 1;
    @(negedge clk); wr_rsp_ready = 0;
  endtask

  task automatic finish_run();
    done_flag = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done_flag) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    tag = "R1";
    check("R1", "reset rd_req_ready", 64'(rd_req_ready), 64'd1);
    check("R1", "reset wr_req_ready", 64'(wr_req_ready), 64'd1);
    check("R1", "reset rd_rsp_valid", 64'(rd_rsp_valid), 64'd0);
    check("R1", "reset wr_rsp_valid", 64'(wr_rsp_valid), 64'd0);
    do_read(12'h000, 0);                 // R1: count reads as zero
    tag = "R7";
    do_read(12'h000, 1);                 // R7: zero minus one is all ones
    do_write(12'h008, 0);
    do_write(12'h008, 0);                // R7: all ones plus one is zero
    do_read(12'h000, 0);
    tag = "R4";
    do_write(12'h008, 4);                // R3 long hold
    do_write(12'h008, 2);
    do_write(12'h008, 0);
    tag = "R5";
    do_read(12'h000, 3);
    do_read(12'h000, 0);
    tag = "R8";
    do_read(12'h010, 1);
    do_write(12'h004, 1);
    do_write(12'h000, 0);
    do_read(12'h008, 0);
    do_read(12'h000, 0);
    tag = "R6";
    @(negedge clk); rd_req_valid = 1; rd_req_addr = 0; wr_req_valid = 1; wr_req_addr = 12'h008;
    @(negedge clk); rd_req_valid = 0; wr_req_valid = 0;
    repeat (2) @(negedge clk);
    rd_rsp_ready = 1; wr_rsp_ready = 1;
    @(negedge clk); rd_rsp_ready = 0; wr_rsp_ready = 0;
    do_read(12'h000, 0);
    tag = "R9";
    @(negedge clk);
    rd_req_valid = 1; rd_req_addr = 0; rd_rsp_ready = 1;
    wr_req_valid = 1; wr_req_addr = 12'h008; wr_rsp_ready = 1;
    repeat (12) @(negedge clk);
    rd_req_valid = 0; wr_req_valid = 0;
    @(negedge clk); rd_rsp_ready = 0; wr_rsp_ready = 0;
    tag = "R5";
    repeat (3000) begin
      @(negedge clk);
      rd_req_valid = ($urandom % 3) == 0;
      rd_req_addr  = (($urandom % 4) == 0) ? 12'h010 : 12'h000;
      rd_rsp_ready = ($urandom % 2) == 0;
      wr_req_valid = ($urandom % 3) == 0;
      wr_req_addr  = (($urandom % 4) == 0) ? 12'h00c : 12'h008;
      wr_rsp_ready = ($urandom % 2) == 0;
    end
    @(negedge clk);
    rd_req_valid = 0; wr_req_valid = 0; rd_rsp_ready = 1; wr_rsp_ready = 1;
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule